// File: doc/BRIEF.md
# Auto-Detecting Pulse-Mode Step Counter

This block holds the 8-bit code of a current-output DAC and decides, from the way the host drives it, which of three control interfaces is in use. Out of reset it assumes the single-line increment-only pulse interface. The first low level seen on chip-select moves it permanently to the three-wire serial interface. While chip-select stays high, the first low level seen on the up/down line moves it permanently to the two-line increment/decrement pulse interface. Only a reset returns it to the start.

In both pulse interfaces every rising edge of the step clock moves the upper six bits of the code by one, which is 4 LSB of the code. The two low bits stay zero. In single-line mode the count wraps from the top to zero. In two-line mode the up/down level sampled with the edge gives the direction, and the count stops at either end. In serial mode the step clock has no effect on the code here, because the serial shifter is a separate block. That shifter uses the high-impedance request output of this block.

All three host lines are asynchronous. They pass through a synchronizer into the system clock before any detection. A code change therefore appears a fixed number of system clocks after the step-clock edge. The interface is made only of plain control and status pins, with no data stream and no handshake.

Top module: `sdac_pulse_ctrl`

## Requirements
- R1: After reset, mode_o is 2'b00 (single-line), code_o is 8'h80 and dout_hiz_o is 1.
- R2: Once chip-select (csn_i) is seen low, mode_o becomes 2'b10 (serial) and stays 2'b10 until reset, whatever the previous mode.
- R3: In single-line mode, when updn_i is seen low while csn_i is high, mode_o becomes 2'b01 (two-line). It never returns to 2'b00 before reset.
- R4: In single-line mode each step-clock rising edge adds 4 to code_o, and 8'hFC plus one step gives 8'h00.
- R5: In two-line mode a step-clock rising edge adds 4 to code_o when updn_i is high and subtracts 4 when it is low.
- R6: In two-line mode code_o stays at 8'hFC on an up step and stays at 8'h00 on a down step. It never wraps.
- R7: code_o[1:0] is always 2'b00.
- R8: dout_hiz_o is 1 in both pulse modes and 0 in serial mode.
- R9: In serial mode, step-clock edges and updn_i changes leave code_o unchanged.
- R10: A step-clock rising edge applied before system clock edge k changes code_o after edge k+2. This comes from two synchronizer stages plus the code register.
- R11: A low on updn_i in single-line mode changes only the mode unless a step edge arrives. If a step edge arrives in the same cycle, that edge already steps down.
- R12: A chip-select low that arrives in the same cycle as a step edge selects serial mode, and the edge does not step the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Chip-select from host, asynchronous, active low |
| updn_i | input | 1 | Up/down (data-in) line from host, asynchronous |
| stepclk_i | input | 1 | Step clock from host, asynchronous |
| mode_o | output | 2 | 00 single-line, 01 two-line, 10 serial |
| code_o | output | 8 | DAC code |
| dout_hiz_o | output | 1 | Request to hold the serial data output in high impedance |

## Verification
Two functions can fall in the same cycle: a mode change and a step. The bench provokes this by driving the first updn_i low, or the first csn_i low, on the same clock as a step-clock rise. Both lines then cross the synchronizer together. The expected result is a down-step already taken in the new two-line mode, or no step at all in the new serial mode. A behavioural model compares mode, code and high-impedance request on every clock. Directed checks pin the absolute values at the wrap, at both saturation points and at the latency boundary.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [1:0] {
    MODE_ONE = 2'b00,
    MODE_TWO = 2'b01,
    MODE_SER = 2'b10
  } mode_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= RST_VAL;
          else        stg_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdac_mode_det.sv
module sdac_mode_det
  import sdac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  csn_s,
  input  logic  updn_s,
  output mode_e mode_q,
  output mode_e mode_nxt
);
  // Sticky detection: serial wins over everything, two-line only from single-line.
  always_comb begin
    mode_nxt = mode_q;
    if (mode_q != MODE_SER) begin
      if (!csn_s)                             mode_nxt = MODE_SER;
      else if (mode_q == MODE_ONE && !updn_s) mode_nxt = MODE_TWO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_ONE;
    else        mode_q <= mode_nxt;
  end
endmodule

// File: rtl/sdac_step_ctr.sv
module sdac_step_ctr
  import sdac_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int LOW_BITS = 2,
  parameter logic [CODE_W-1:0] RST_CODE = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stepclk_s,
  input  logic              updn_s,
  input  mode_e             mode_nxt,
  output logic [CODE_W-1:0] code_o
);
  localparam int CNT_W = CODE_W - LOW_BITS;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_RST = RST_CODE[CODE_W-1:LOW_BITS];

  logic             clk_prev_q;
  logic             rise;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev_q <= 1'b0;
    else        clk_prev_q <= stepclk_s;
  end

  assign rise = stepclk_s & ~clk_prev_q;

  // The step uses the mode being entered this cycle, so a switch and an edge
  // that arrive together act in the new mode.
  always_comb begin
    cnt_d = cnt_q;
    if (rise) begin
      unique case (mode_nxt)
        MODE_ONE: cnt_d = cnt_q + 1'b1;
        MODE_TWO: begin
          if (updn_s) begin
            if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
          end else begin
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_RST;
    else        cnt_q <= cnt_d;
  end

  assign code_o = {cnt_q, {LOW_BITS{1'b0}}};
endmodule

// File: rtl/sdac_pulse_ctrl.sv
module sdac_pulse_ctrl
  import sdac_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int LOW_BITS = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] RST_CODE = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_i,
  input  logic              updn_i,
  input  logic              stepclk_i,
  output logic [1:0]        mode_o,
  output logic [CODE_W-1:0] code_o,
  output logic              dout_hiz_o
);
  localparam int N_IN = 3;
  localparam logic [N_IN-1:0] IDLE = 3'b110; // {csn, updn, stepclk}

  logic [N_IN-1:0] in_s;
  mode_e           mode_q, mode_nxt;

  sdac_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({csn_i, updn_i, stepclk_i}),
    .sync_o  (in_s)
  );

  sdac_mode_det u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn_s    (in_s[2]),
    .updn_s   (in_s[1]),
    .mode_q   (mode_q),
    .mode_nxt (mode_nxt)
  );

  sdac_step_ctr #(.CODE_W(CODE_W), .LOW_BITS(LOW_BITS), .RST_CODE(RST_CODE)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .stepclk_s (in_s[0]),
    .updn_s    (in_s[1]),
    .mode_nxt  (mode_nxt),
    .code_o    (code_o)
  );

  assign mode_o     = mode_q;
  assign dout_hiz_o = (mode_q != MODE_SER);
endmodule

// File: rtl/sdac_pulse_chk.sv
module sdac_pulse_chk #(
  parameter int CODE_W = 8,
  parameter int LOW_BITS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic [CODE_W-1:0] code,
  input logic              hiz
);
  localparam logic [CODE_W-1:0] STEP = CODE_W'(1) << LOW_BITS;
  localparam logic [CODE_W-1:0] TOP  = ~((CODE_W'(1) << LOW_BITS) - CODE_W'(1));

  // R2
  ser_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |=> mode == 2'b10);
  // R3
  two_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |=> mode != 2'b00);
  // R2
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);
  // R4
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code != $past(code) |-> (code == $past(code) + STEP || code == $past(code) - STEP));
  // R6
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && $past(mode) == 2'b01 && $past(code) == TOP) |-> code != '0);
  // R6
  no_wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && $past(mode) == 2'b01 && $past(code) == '0) |-> code != TOP);
  // R7
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code[LOW_BITS-1:0] == '0);
  // R9
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode) == 2'b10 |-> $stable(code));
  // R8
  hiz_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hiz |=> !hiz);
endmodule

bind sdac_pulse_ctrl sdac_pulse_chk #(.CODE_W(CODE_W), .LOW_BITS(LOW_BITS)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .mode  (mode_o),
  .code  (code_o),
  .hiz   (dout_hiz_o)
);

// File: tb/test_sdac_pulse_ctrl.sv
`timescale 1ns/1ps
module test_sdac_pulse_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csn = 1'b1, updn = 1'b1, sck = 1'b0;
  logic [1:0] mode;
  logic [7:0] code;
  logic       hiz;

  int n_run = 0, n_fail = 0;
  bit done = 0, armed = 0;

  always #2.5 clk = ~clk;

  sdac_pulse_ctrl i_sdac_pulse_ctrl (
    .clk(clk), .rst_n(rst_n), .csn_i(csn), .updn_i(updn), .stepclk_i(sck),
    .mode_o(mode), .code_o(code), .dout_hiz_o(hiz)
  );

  // Behavioural reference: inputs seen two clocks late, edge against the sample before.
  logic [2:0] hist[$];
  int m_mode = 0;
  int m_cnt = 32;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 32;
      hist.delete();
      repeat (3) hist.push_back(3'b110);
    end else begin
      logic [2:0] cur, old;
      hist.push_back({csn, updn, sck});
      cur = hist[1]; old = hist[0];
      void'(hist.pop_front());
      if (m_mode != 2) begin
        if (!cur[2]) m_mode = 2;
        else if (m_mode == 0 && !cur[1]) m_mode = 1;
      end
      if (cur[0] && !old[0]) begin
        if (m_mode == 0) m_cnt = (m_cnt + 1) % 64;
        else if (m_mode == 1) begin
          if (cur[1] && m_cnt < 63) m_cnt++;
          else if (!cur[1] && m_cnt > 0) m_cnt--;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (armed && rst_n) begin
    chk("R2/R3 mode vs model", mode, m_mode);
    chk("R4/R5/R6 code vs model", code, m_cnt * 4);
    chk("R8 hiz vs model", hiz, (m_mode != 2));
    chk("R7 low bits", code[1:0], 0);
  end

  task automatic do_reset();
    rst_n = 1'b0; csn = 1'b1; updn = 1'b1; sck = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b1; repeat (2) @(negedge clk);
      sck = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    armed = 1;
    // R1 reset state
    chk("R1 mode", mode, 0); chk("R1 code", code, 8'h80); chk("R1 hiz", hiz, 1);

    // R10 latency: rise before edge k, change after edge k+2
    sck = 1'b1;
    @(negedge clk); chk("R10 code +1", code, 8'h80);
    @(negedge clk); chk("R10 code +2", code, 8'h80);
    @(negedge clk); chk("R10 code +3", code, 8'h84);
    sck = 1'b0; repeat (3) @(negedge clk);

    // R4 wrap: 31 more edges from 0x84 reach 0x00
    pulse(31); chk("R4 wrap to 00", code, 8'h00);
    pulse(5);  chk("R4 after wrap", code, 8'h14);

    // R11 updn low with no edge: mode only
    do_reset();
    updn = 1'b0; repeat (4) @(negedge clk);
    chk("R11 mode 2-line", mode, 1); chk("R11 code kept", code, 8'h80);
    updn = 1'b1; repeat (4) @(negedge clk);
    chk("R3 stays 2-line", mode, 1);

    // R11 updn low coinciding with an edge: steps down at once
    do_reset();
    updn = 1'b0; sck = 1'b1; repeat (4) @(negedge clk);
    chk("R11 coincident mode", mode, 1); chk("R11 coincident down", code, 8'h7C);
    sck = 1'b0; updn = 1'b1; repeat (3) @(negedge clk);

    // R5 / R6 up to saturation
    pulse(40); chk("R6 top saturation", code, 8'hFC);
    updn = 1'b0; repeat (3) @(negedge clk);
    pulse(3); chk("R5 down steps", code, 8'hF0);
    pulse(70); chk("R6 bottom saturation", code, 8'h00);
    updn = 1'b1; pulse(2); chk("R5 up steps", code, 8'h08);
    chk("R8 hiz in 2-line", hiz, 1);

    // R2 from 2-line; R9 edges ignored in serial
    csn = 1'b0; repeat (4) @(negedge clk);
    chk("R2 serial from 2-line", mode, 2); chk("R8 hiz serial", hiz, 0);
    csn = 1'b1; pulse(4); chk("R9 code held", code, 8'h08);
    updn = 1'b0; pulse(3); chk("R9 updn ignored", code, 8'h08);
    chk("R2 still serial", mode, 2);

    // R12 chip-select low together with an edge: serial, no step
    do_reset();
    csn = 1'b0; sck = 1'b1; repeat (4) @(negedge clk);
    chk("R12 mode serial", mode, 2); chk("R12 no step", code, 8'h80);
    sck = 1'b0; csn = 1'b1; repeat (3) @(negedge clk);

    // R1 reset leaves serial
    do_reset();
    chk("R1 mode after reset", mode, 0); chk("R1 hiz after reset", hiz, 1);
    pulse(2); chk("R4 steps after reset", code, 8'h88);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule